// File: doc/BRIEF.md
# Calendar-Driven FIFO Status Channel Generator

This block produces the receive-side status stream of a packet interface in the SPI-4.2 style. A programmable calendar lists port numbers. For each calendar entry, the block sends one 2-bit flow-control code for that port, one code per clock. The code is derived from the port's FIFO fill level compared against two thresholds, from an external per-port status input, or from the more restrictive of the two.

A frame begins with the framing code `11`. The framing code is followed by the calendar body, repeated a programmable number of times. The frame closes with a 2-bit odd-parity trailer computed over the body codes. The next frame starts on the following cycle.

A companion checker parses a status stream fed back on a loop input. It recomputes the trailer and counts mismatching frames in a saturating 8-bit counter. A test input inverts the transmitted trailer so that the checker path can be exercised.

Top module: `stat_chan_gen`

## Requirements
- R1: While reset is held, `stat_out` is `00` and `err_count` is 0. On the first clock edge after reset, `stat_out` becomes the framing code `11`.
- R2: After the framing code, one code per cycle is sent for calendar entries 0 to `cal_len`-1, in that order. Entry i names the port held in `cal_ports[i*PORT_W +: PORT_W]`.
- R3: Every frame starts with `11`, and a body code is never `11`.
- R4: In fill mode, the code is chosen as follows:
  - A level below `thr_hungry` gives `00` (starving).
  - A level at or above `thr_hungry` and below `thr_satisfied` gives `01` (hungry).
  - A level at or above `thr_satisfied` gives `10` (satisfied).
- R5: `src_mode` selects the source of each code:
  - 0 selects fill mode.
  - 1 selects the external 2-bit code, where an external `11` is sent as `10`.
  - 2 or 3 selects the numerically larger of the fill code and the external code.
- R6: The calendar body is sent `cal_reps` times between the framing code and the trailer.
- R7: The trailer is the bitwise inverse of the column-wise XOR of all body codes in the frame.
- R8: With `force_dip_err` high, both trailer bits are inverted.
- R9: Each frame on `loop_stat` whose trailer fails the R7 rule adds one to `err_count` on the edge after the trailer arrives. The count saturates at 255.
- R10: `err_clr` sets `err_count` to 0 on the next edge. It takes priority over a count.
- R11: With `loop_stat` fed from `stat_out` and no forcing, `err_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_ports | input | CAL_DEPTH*PORT_W | Calendar entries, port number per entry |
| cal_len | input | CNT_W | Number of active calendar entries (1..CAL_DEPTH) |
| cal_reps | input | REP_W | Body repetitions per frame (>=1) |
| fill_levels | input | NPORTS*LVL_W | Per-port FIFO fill levels |
| ext_status | input | NPORTS*2 | Per-port external status codes |
| src_mode | input | 2 | Status source selection |
| thr_hungry | input | LVL_W | Starving/hungry boundary |
| thr_satisfied | input | LVL_W | Hungry/satisfied boundary |
| force_dip_err | input | 1 | Invert the transmitted trailer |
| loop_stat | input | 2 | Looped-back status stream for checking |
| err_clr | input | 1 | Synchronous clear of the error counter |
| stat_out | output | 2 | Status channel output |
| err_count | output | 8 | Saturating trailer error count |

## Verification
The bench builds the block with the default parameters: four ports, 6-bit levels, a 16-entry calendar and a 4-bit repetition count. With 6-bit levels, thresholds can be placed so that levels sit exactly on each boundary. The full 16-entry calendar is driven with three repetitions, which gives 50-cycle frames. The 4-bit repetition count also allows the repetition path to be tested with a short calendar. Single-entry calendars give 3-cycle frames, which push the error counter past 255 and into a clear within a short run.

// File: rtl/stat_chan_pkg.sv
package stat_chan_pkg;
  localparam logic [1:0] CODE_STARVE = 2'b00;
  localparam logic [1:0] CODE_HUNGRY = 2'b01;
  localparam logic [1:0] CODE_SAT    = 2'b10;
  localparam logic [1:0] CODE_FRAME  = 2'b11;

  typedef enum logic [1:0] {PH_SYNC, PH_BODY, PH_DIP} gen_phase_e;
  typedef enum logic [1:0] {CK_HUNT, CK_BODY, CK_CHECK} chk_phase_e;

  // Threshold classification of a fill level (zero-extended to 16 bits).
  function automatic logic [1:0] level_code(input logic [15:0] lvl,
                                            input logic [15:0] thr_h,
                                            input logic [15:0] thr_s);
    if (lvl < thr_h)      return CODE_STARVE;
    else if (lvl < thr_s) return CODE_HUNGRY;
    else                  return CODE_SAT;
  endfunction

  // Source selection; the reserved framing value never leaves this function.
  function automatic logic [1:0] merge_code(input logic [1:0] fill_c,
                                            input logic [1:0] ext_c,
                                            input logic [1:0] mode);
    logic [1:0] ext_safe;
    ext_safe = (ext_c == CODE_FRAME) ? CODE_SAT : ext_c;
    case (mode)
      2'd0:    return fill_c;
      2'd1:    return ext_safe;
      default: return (fill_c > ext_safe) ? fill_c : ext_safe;
    endcase
  endfunction

  // Odd-parity trailer from the running XOR, with optional inversion.
  function automatic logic [1:0] dip_trailer(input logic [1:0] acc,
                                             input logic       force_err);
    return ~acc ^ {2{force_err}};
  endfunction
endpackage

// File: rtl/stat_port_sel.sv
module stat_port_sel
  import stat_chan_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int LVL_W  = 6,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [PORT_W-1:0]       port,
  input  logic [NPORTS*LVL_W-1:0] fill_levels,
  input  logic [NPORTS*2-1:0]     ext_status,
  input  logic [1:0]              src_mode,
  input  logic [LVL_W-1:0]        thr_hungry,
  input  logic [LVL_W-1:0]        thr_satisfied,
  output logic [1:0]              code
);
  logic [1:0] port_code [NPORTS];

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign port_code[g] = merge_code(
      level_code(16'(fill_levels[g*LVL_W +: LVL_W]), 16'(thr_hungry), 16'(thr_satisfied)),
      ext_status[g*2 +: 2], src_mode);
  end

  assign code = port_code[port];

  always_comb begin
    assert (code != CODE_FRAME);  // AST_CODE_NOT_FRAME R3
  end
endmodule

// File: rtl/stat_framer.sv
module stat_framer
  import stat_chan_pkg::*;
#(
  parameter int CAL_DEPTH = 16,
  parameter int PORT_W    = 2,
  parameter int REP_W     = 4,
  localparam int IDX_W = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1,
  localparam int CNT_W = $clog2(CAL_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CAL_DEPTH*PORT_W-1:0] cal_ports,
  input  logic [CNT_W-1:0]            cal_len,
  input  logic [REP_W-1:0]            cal_reps,
  input  logic [1:0]                  slot_code,
  input  logic                        force_dip_err,
  output logic [PORT_W-1:0]           slot_port,
  output logic [1:0]                  stat_out
);
  gen_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic [REP_W-1:0] rep;
  logic [1:0]       acc;

  // Named events for the assertions.
  logic sync_emit, body_emit, dip_emit, last_entry, last_rep;
  assign sync_emit  = (phase == PH_SYNC);
  assign body_emit  = (phase == PH_BODY);
  assign dip_emit   = (phase == PH_DIP);
  assign last_entry = ((CNT_W'(idx) + 1'b1) >= cal_len);
  assign last_rep   = (({1'b0, rep} + 1'b1) >= {1'b0, cal_reps});
  assign slot_port  = cal_ports[idx*PORT_W +: PORT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_SYNC;
      idx      <= '0;
      rep      <= '0;
      acc      <= '0;
      stat_out <= CODE_STARVE;
    end else begin
      unique case (phase)
        PH_SYNC: begin
          stat_out <= CODE_FRAME;
          acc      <= '0;
          idx      <= '0;
          rep      <= '0;
          phase    <= PH_BODY;
        end
        PH_BODY: begin
          stat_out <= slot_code;
          acc      <= acc ^ slot_code;
          if (last_entry) begin
            idx <= '0;
            rep <= rep + 1'b1;
            if (last_rep) phase <= PH_DIP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          stat_out <= dip_trailer(acc, force_dip_err);
          phase    <= PH_SYNC;
        end
      endcase
    end
  end

  AST_SYNC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_emit |=> stat_out == CODE_FRAME);  // R3
  AST_BODY_NOT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    body_emit |=> stat_out != CODE_FRAME);  // R3
  AST_DIP_THEN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dip_emit |=> sync_emit);  // R6
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sync_emit, body_emit, dip_emit}));  // R2
endmodule

// File: rtl/stat_dip_checker.sv
module stat_dip_checker
  import stat_chan_pkg::*;
#(
  parameter int CAL_DEPTH = 16,
  parameter int REP_W     = 4,
  parameter int ERR_W     = 8,
  localparam int IDX_W   = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1,
  localparam int CNT_W   = $clog2(CAL_DEPTH + 1),
  localparam logic [ERR_W-1:0] ERR_MAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       loop_stat,
  input  logic [CNT_W-1:0] cal_len,
  input  logic [REP_W-1:0] cal_reps,
  input  logic             err_clr,
  output logic [ERR_W-1:0] err_count
);
  chk_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic [REP_W-1:0] rep;
  logic [1:0]       acc;

  logic end_entry, end_rep, dip_bad;
  assign end_entry = ((CNT_W'(idx) + 1'b1) >= cal_len);
  assign end_rep   = (({1'b0, rep} + 1'b1) >= {1'b0, cal_reps});
  assign dip_bad   = (phase == CK_CHECK) && (loop_stat != dip_trailer(acc, 1'b0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= CK_HUNT;
      idx   <= '0;
      rep   <= '0;
      acc   <= '0;
    end else begin
      unique case (phase)
        CK_HUNT: begin
          idx <= '0;
          rep <= '0;
          acc <= '0;
          if (loop_stat == CODE_FRAME) phase <= CK_BODY;
        end
        CK_BODY: begin
          acc <= acc ^ loop_stat;
          if (end_entry) begin
            idx <= '0;
            rep <= rep + 1'b1;
            if (end_rep) phase <= CK_CHECK;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= CK_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || err_clr)                 err_count <= '0;
    else if (dip_bad && err_count != ERR_MAX) err_count <= err_count + 1'b1;
  end

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX && !err_clr) |=> err_count == ERR_MAX);  // R9
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));  // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err_count == '0);  // R10
endmodule

// File: rtl/stat_chan_gen.sv
module stat_chan_gen
  import stat_chan_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int LVL_W     = 6,
  parameter int CAL_DEPTH = 16,
  parameter int REP_W     = 4,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CNT_W  = $clog2(CAL_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CAL_DEPTH*PORT_W-1:0] cal_ports,
  input  logic [CNT_W-1:0]            cal_len,
  input  logic [REP_W-1:0]            cal_reps,
  input  logic [NPORTS*LVL_W-1:0]     fill_levels,
  input  logic [NPORTS*2-1:0]         ext_status,
  input  logic [1:0]                  src_mode,
  input  logic [LVL_W-1:0]            thr_hungry,
  input  logic [LVL_W-1:0]            thr_satisfied,
  input  logic                        force_dip_err,
  input  logic [1:0]                  loop_stat,
  input  logic                        err_clr,
  output logic [1:0]                  stat_out,
  output logic [7:0]                  err_count
);
  logic [PORT_W-1:0] slot_port;
  logic [1:0]        slot_code;

  stat_port_sel #(.NPORTS(NPORTS), .LVL_W(LVL_W)) u_sel (
    .port(slot_port), .fill_levels(fill_levels), .ext_status(ext_status),
    .src_mode(src_mode), .thr_hungry(thr_hungry), .thr_satisfied(thr_satisfied),
    .code(slot_code));

  stat_framer #(.CAL_DEPTH(CAL_DEPTH), .PORT_W(PORT_W), .REP_W(REP_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .cal_ports(cal_ports), .cal_len(cal_len),
    .cal_reps(cal_reps), .slot_code(slot_code), .force_dip_err(force_dip_err),
    .slot_port(slot_port), .stat_out(stat_out));

  stat_dip_checker #(.CAL_DEPTH(CAL_DEPTH), .REP_W(REP_W), .ERR_W(8)) u_chk (
    .clk(clk), .rst_n(rst_n), .loop_stat(loop_stat), .cal_len(cal_len),
    .cal_reps(cal_reps), .err_clr(err_clr), .err_count(err_count));

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (stat_out == CODE_STARVE && err_count == 8'd0));  // R1
endmodule

// File: tb/stat_chan_gen_bench.sv
module stat_chan_gen_bench;
  localparam int CLK_NS = 10;
  localparam int NP = 4, LW = 6, CD = 16, RW = 4, PW = 2, CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CD*PW-1:0] cal_ports;
  logic [CW-1:0] cal_len;
  logic [RW-1:0] cal_reps;
  logic [NP*LW-1:0] fill_levels;
  logic [NP*2-1:0] ext_status;
  logic [1:0] src_mode;
  logic [LW-1:0] thr_hungry, thr_satisfied;
  logic force_dip_err = 1'b0;
  logic err_clr = 1'b0;
  logic [1:0] stat_out, loop_stat;
  logic [7:0] err_count;

  assign loop_stat = stat_out;

  stat_chan_gen u_stat_chan_gen (
    .clk(clk), .rst_n(rst_n), .cal_ports(cal_ports), .cal_len(cal_len),
    .cal_reps(cal_reps), .fill_levels(fill_levels), .ext_status(ext_status),
    .src_mode(src_mode), .thr_hungry(thr_hungry), .thr_satisfied(thr_satisfied),
    .force_dip_err(force_dip_err), .loop_stat(loop_stat), .err_clr(err_clr),
    .stat_out(stat_out), .err_count(err_count));

  always #(CLK_NS/2) clk = ~clk;

  typedef struct { logic [1:0] code; bit is_dip; string req; } item_t;
  item_t exp_q[$];
  int n_checks = 0, n_errs = 0;
  bit mon_on = 0, prev_fd = 0, finished = 0;
  int exp_err = 0;
  int cal[CD];
  int lvl[NP];
  int ext[NP];

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] bcode(int p);
    logic [1:0] f, e;
    if (lvl[p] < int'(thr_hungry)) f = 2'd0;
    else if (lvl[p] < int'(thr_satisfied)) f = 2'd1;
    else f = 2'd2;
    e = (ext[p] == 3) ? 2'd2 : 2'(ext[p]);
    if (src_mode == 2'd0) return f;
    if (src_mode == 2'd1) return e;
    return (f > e) ? f : e;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < CD; i++) cal_ports[i*PW +: PW] = PW'(cal[i]);
    for (int p = 0; p < NP; p++) begin
      fill_levels[p*LW +: LW] = LW'(lvl[p]);
      ext_status[p*2 +: 2] = 2'(ext[p]);
    end
  endtask

  // Driver: push expected frames, then run the design through them.
  task automatic run_phase(int nframes, string tag);
    logic [1:0] acc;
    item_t it;
    apply_cfg();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(stat_out == 2'b00, "R1 reset stat_out", int'(stat_out), 0);
    check(err_count == 8'd0, "R1 reset err_count", int'(err_count), 0);
    for (int f = 0; f < nframes; f++) begin
      acc = 2'b00;
      it.code = 2'b11; it.is_dip = 0; it.req = (f == 0) ? "R1 R3 first sync" : "R3 sync";
      exp_q.push_back(it);
      for (int r = 0; r < int'(cal_reps); r++)
        for (int e = 0; e < int'(cal_len); e++) begin
          it.code = bcode(cal[e]); it.is_dip = 0; it.req = tag;
          acc = acc ^ it.code;
          exp_q.push_back(it);
        end
      it.code = ~acc ^ {2{force_dip_err}}; it.is_dip = 1;
      it.req = force_dip_err ? "R8 forced trailer" : "R7 trailer";
      exp_q.push_back(it);
    end
    exp_err = 0; prev_fd = 0;
    rst_n = 1'b1;
    mon_on = 1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 0;
    rst_n = 1'b0;
  endtask

  // Monitor: pop expected items and model the error counter.
  initial forever begin
    @(posedge clk);
    #(CLK_NS/4);
    if (mon_on) begin
      item_t it;
      string etag;
      etag = err_clr ? "R10 clear" : (force_dip_err ? "R9 count" : "R11 no errors");
      if (err_clr) exp_err = 0;
      else if (prev_fd && exp_err < 255) exp_err++;
      check(int'(err_count) == exp_err, etag, int'(err_count), exp_err);
      prev_fd = 0;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check(stat_out == it.code, it.req, int'(stat_out), int'(it.code));
        prev_fd = it.is_dip && force_dip_err;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    thr_hungry = 6'd16; thr_satisfied = 6'd32;
    cal_ports = '0; fill_levels = '0; ext_status = '0;
    for (int i = 0; i < CD; i++) cal[i] = 0;
    // P1 R2 R4: fill mode, levels on both threshold boundaries.
    lvl = '{15, 16, 31, 32}; ext = '{3, 3, 3, 3};
    src_mode = 2'd0; cal_len = 5'd5; cal_reps = 4'd1;
    cal[0] = 3; cal[1] = 0; cal[2] = 1; cal[3] = 2; cal[4] = 1;
    run_phase(3, "R2 R4 fill order");
    // P2 R5 R6: external mode, 11 clamped, body repeated twice.
    lvl = '{63, 0, 0, 63}; ext = '{1, 3, 0, 2};
    src_mode = 2'd1; cal_len = 5'd3; cal_reps = 4'd2;
    cal[0] = 1; cal[1] = 3; cal[2] = 2;
    run_phase(3, "R5 R6 external");
    // P3 R5 R2: merged mode over a full 16-entry calendar, three passes.
    lvl = '{15, 16, 31, 32}; ext = '{2, 0, 1, 0};
    src_mode = 2'd2; cal_len = 5'd16; cal_reps = 4'd3;
    for (int i = 0; i < CD; i++) cal[i] = (i * 3 + i / 4) % 4;
    run_phase(3, "R2 R5 merged");
    // P4 R8 R9 R10: forced trailers, saturation, then a clear.
    lvl = '{0, 0, 40, 0}; ext = '{0, 0, 0, 0};
    src_mode = 2'd0; cal_len = 5'd1; cal_reps = 4'd1; cal[0] = 2;
    force_dip_err = 1'b1;
    fork
      run_phase(300, "R4 single entry");
      begin
        repeat (830) @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
      end
    join
    force_dip_err = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule